// File: doc/BRIEF.md
# Serial Command-Driven Register Store (Three-Wire Slave)

This block is the device side of a three-wire synchronous serial link: a select line, a serial clock and a data input, with one data output. Behind the link sits a small store of sixteen 16-bit words that behaves like a non-volatile memory. It can be read, written, erased word by word or all at once, and it is protected by a write-enable latch. The block runs on a fast system clock and oversamples the serial clock, so the serial clock may be arbitrarily slow or may pause.

Each selection of the device carries exactly one instruction. After select goes high, the first 1 seen on the data input is the start bit. Eight instruction bits follow it. A read answers with a 0 placeholder bit and then the addressed word. A write, or a write-all, is followed by 16 data bits. Any change to the store waits for the select-low interval after the instruction. It takes effect only if select stays low for a parameterised number of system-clock cycles. That count stands in for the programming pulse of a real cell.

Top module: `mw_regfile_slave`

## Requirements
- R1: After reset the output is 0, every stored word reads as 16'h0000, and modification is disabled.
- R2: Input bits are taken on rising edges of the serial clock. While select is high, 0 bits before the first 1 are skipped, and that first 1 is the start bit.
- R3: After the start bit come 8 instruction bits, sent most significant bit first. Bits [7:6] hold the operation: 00 read, 10 write, 01 erase, 11 extended. For read, write and erase, bits [3:0] are the word address and bits [5:4] are don't-care. For extended, bits [5:3] must be 000 and bits [2:0] select the function: 001 enable, 010 disable, 100 write-all, 101 erase-all. Any other extended pattern has no effect.
- R4: After a read instruction, the output shows 0 once the last address bit has been taken. Each of the next 16 rising edges then presents one bit of the word, most significant bit first. The data input is ignored throughout.
- R5: Once all 16 read bits have been shown, the next rising edge switches the output to follow the data input until select goes low.
- R6: A write takes 16 data bits, most significant bit first, after its instruction. The word is stored once select has then stayed low for PROG_CYCLES system clocks.
- R7: An erase sets the addressed word to 16'hFFFF under the same commit rule as R6.
- R8: A write-all takes 16 data bits and stores them in every word. An erase-all sets every word to 16'hFFFF. Both follow the same commit rule as R6.
- R9: Write, erase, write-all and erase-all change nothing unless an enable instruction has been completed since reset or since the last disable.
- R10: If select drops before the instruction or its data bits are complete, nothing is stored.
- R11: If select rises again before PROG_CYCLES low cycles have elapsed, the pending change is dropped.
- R12: After an instruction completes, further serial-clock edges and data are ignored until select goes low and high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Device select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data input |
| do_o | output | 1 | Serial data output |

## Verification
A missed or doubled serial-clock edge in the decoder moves every later bit by one position. The next read shows this within its 17 output samples, either as a nonzero placeholder bit or as a rotated word. A wrong enable latch, or a wrong pending-change flag, stays hidden at the ports until the select-low interval has passed. It only shows when the affected word is read back, so every modifying instruction is followed by a read of the words it could have touched.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_CMD,
    ST_WDATA,
    ST_RDATA,
    ST_ECHO,
    ST_HOLD
  } mw_state_e;

  typedef enum logic [1:0] {
    PG_WRITE,
    PG_ERASE,
    PG_FILL,
    PG_WIPE
  } mw_prog_e;

  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b01;
  localparam logic [1:0] OP_EXT   = 2'b11;

  localparam logic [2:0] SUB_EN   = 3'b001;
  localparam logic [2:0] SUB_DIS  = 3'b010;
  localparam logic [2:0] SUB_FILL = 3'b100;
  localparam logic [2:0] SUB_WIPE = 3'b101;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sk_rise_i,
  input  logic              di_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              do_o,
  output logic              arm_o,
  output mw_prog_e          arm_kind_o,
  output logic [ADDR_W-1:0] arm_addr_o,
  output logic [DATA_W-1:0] arm_data_o
);

  localparam int CMD_BITS = ADDR_W + 4;
  localparam int CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] RD_END   = CNT_W'(DATA_W);

  mw_state_e           state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [CMD_BITS-2:0] cmd_q, cmd_d;
  logic [DATA_W-1:0]   dat_q, dat_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  mw_prog_e            kind_q, kind_d;
  logic                en_q, en_d;
  logic                do_q, do_d;

  logic [CMD_BITS-1:0] cmd_word;
  logic [1:0]          opcode;
  logic [2:0]          sub;
  logic                ext_zero;
  logic [DATA_W-1:0]   dat_word;

  assign cmd_word  = {cmd_q, di_i};
  assign opcode    = cmd_word[CMD_BITS-1 -: 2];
  assign sub       = cmd_word[2:0];
  assign ext_zero  = (cmd_word[CMD_BITS-3:3] == '0);
  assign dat_word  = {dat_q[DATA_W-2:0], di_i};
  assign rd_addr_o = cmd_word[ADDR_W-1:0];

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cmd_d      = cmd_q;
    dat_d      = dat_q;
    addr_d     = addr_q;
    kind_d     = kind_q;
    en_d       = en_q;
    do_d       = do_q;
    arm_o      = 1'b0;
    arm_kind_o = kind_q;
    arm_addr_o = addr_q;
    arm_data_o = dat_word;
    if (!cs_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      do_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_HUNT;
          cnt_d   = '0;
          do_d    = 1'b0;
        end
        ST_HUNT: begin
          if (sk_rise_i && di_i) begin
            state_d = ST_CMD;
            cnt_d   = '0;
          end
        end
        ST_CMD: begin
          if (sk_rise_i) begin
            cmd_d = cmd_word[CMD_BITS-2:0];
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CMD_LAST) begin
              cnt_d   = '0;
              addr_d  = rd_addr_o;
              state_d = ST_HOLD;
              unique case (opcode)
                OP_READ: begin
                  dat_d   = rd_data_i;
                  do_d    = 1'b0;
                  state_d = ST_RDATA;
                end
                OP_WRITE: begin
                  kind_d  = PG_WRITE;
                  state_d = ST_WDATA;
                end
                OP_ERASE: begin
                  arm_o      = en_q;
                  arm_kind_o = PG_ERASE;
                  arm_addr_o = rd_addr_o;
                end
                default: begin
                  if (ext_zero) begin
                    unique case (sub)
                      SUB_EN:   en_d = 1'b1;
                      SUB_DIS:  en_d = 1'b0;
                      SUB_FILL: begin
                        kind_d  = PG_FILL;
                        state_d = ST_WDATA;
                      end
                      SUB_WIPE: begin
                        arm_o      = en_q;
                        arm_kind_o = PG_WIPE;
                      end
                      default: ;
                    endcase
                  end
                end
              endcase
            end
          end
        end
        ST_WDATA: begin
          if (sk_rise_i) begin
            dat_d = dat_word;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == DAT_LAST) begin
              arm_o   = en_q;
              state_d = ST_HOLD;
            end
          end
        end
        ST_RDATA: begin
          if (sk_rise_i) begin
            if (cnt_q == RD_END) begin
              state_d = ST_ECHO;
            end else begin
              do_d  = dat_q[DATA_W-1];
              dat_d = {dat_q[DATA_W-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      dat_q   <= '0;
      addr_q  <= '0;
      kind_q  <= PG_WRITE;
      en_q    <= 1'b0;
      do_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cmd_q   <= cmd_d;
      dat_q   <= dat_d;
      addr_q  <= addr_d;
      kind_q  <= kind_d;
      en_q    <= en_d;
      do_q    <= do_d;
    end
  end

  assign do_o = (state_q == ST_ECHO) ? di_i : do_q;

  assert_dummy_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_RDATA) |-> (do_o == 1'b0));

  assert_one_instr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && cs_i) |=> (state_q == ST_HOLD));

  assert_drop_on_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (state_q == ST_IDLE && !do_o));

endmodule

// File: rtl/mw_prog_seq.sv
module mw_prog_seq
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              cs_rise_i,
  input  logic              arm_i,
  input  mw_prog_e          arm_kind_i,
  input  logic [ADDR_W-1:0] arm_addr_i,
  input  logic [DATA_W-1:0] arm_data_i,
  output logic              apply_o,
  output mw_prog_e          kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int TMR_W = $clog2(PROG_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(PROG_CYCLES - 1);

  logic              pend_q, pend_d;
  mw_prog_e          kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;

  assign apply_o = pend_q && !cs_i && (tmr_q == TMR_LAST);

  always_comb begin
    pend_d = pend_q;
    kind_d = kind_q;
    addr_d = addr_q;
    data_d = data_q;
    tmr_d  = tmr_q;
    if (cs_rise_i) begin
      pend_d = 1'b0;
      tmr_d  = '0;
    end else if (arm_i) begin
      pend_d = 1'b1;
      kind_d = arm_kind_i;
      addr_d = arm_addr_i;
      data_d = arm_data_i;
      tmr_d  = '0;
    end else if (pend_q && !cs_i) begin
      if (apply_o) pend_d = 1'b0;
      else         tmr_d  = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      kind_q <= PG_WRITE;
      addr_q <= '0;
      data_q <= '0;
      tmr_q  <= '0;
    end else begin
      pend_q <= pend_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
      data_q <= data_d;
      tmr_q  <= tmr_d;
    end
  end

  assign kind_o = kind_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  assert_commit_deselected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_o |-> !cs_i);

  assert_drop_on_reselect_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> !pend_q);

endmodule

// File: rtl/mw_store.sv
module mw_store
  import mw_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              apply_i,
  input  mw_prog_e          kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int NREG = 1 << ADDR_W;

  logic [NREG-1:0][DATA_W-1:0] mem_q, mem_d;
  logic [NREG-1:0]             we;
  logic [DATA_W-1:0]           wval;
  logic                        all_tgt;

  assign all_tgt = (kind_i == PG_FILL) || (kind_i == PG_WIPE);
  assign wval    = ((kind_i == PG_WRITE) || (kind_i == PG_FILL)) ? data_i : '1;

  for (genvar i = 0; i < NREG; i++) begin : g_we
    assign we[i] = apply_i && (all_tgt || (addr_i == ADDR_W'(i)));
  end

  always_comb begin
    mem_d = mem_q;
    for (int i = 0; i < NREG; i++) begin
      if (we[i]) mem_d[i] = wval;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else         mem_q <= mem_d;
  end

  assign rd_data_o = mem_q[rd_addr_i];

  assert_erase_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && kind_i == PG_ERASE) |=> (mem_q[$past(addr_i)] == '1));

  assert_fill_every_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && kind_i == PG_FILL) |=>
      (mem_q[0] == $past(data_i) && mem_q[NREG-1] == $past(data_i)));

endmodule

// File: rtl/mw_regfile_slave.sv
module mw_regfile_slave
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  logic [2:0] pins_s;
  logic       cs_s, sk_s, di_s;
  logic       cs_prev_q, sk_prev_q;
  logic       sk_rise, cs_rise;

  mw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   ({cs_i, sk_i, di_i}),
    .q_o   (pins_s)
  );

  assign cs_s = pins_s[2];
  assign sk_s = pins_s[1];
  assign di_s = pins_s[0];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q <= 1'b0;
      sk_prev_q <= 1'b0;
    end else begin
      cs_prev_q <= cs_s;
      sk_prev_q <= sk_s;
    end
  end

  assign sk_rise = sk_s && !sk_prev_q;
  assign cs_rise = cs_s && !cs_prev_q;

  logic [ADDR_W-1:0] rd_addr, arm_addr, pg_addr;
  logic [DATA_W-1:0] rd_data, arm_data, pg_data;
  logic              arm, apply;
  mw_prog_e          arm_kind, pg_kind;

  mw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .cs_i      (cs_s),
    .sk_rise_i (sk_rise),
    .di_i      (di_s),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .do_o      (do_o),
    .arm_o     (arm),
    .arm_kind_o(arm_kind),
    .arm_addr_o(arm_addr),
    .arm_data_o(arm_data)
  );

  mw_prog_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .cs_i      (cs_s),
    .cs_rise_i (cs_rise),
    .arm_i     (arm),
    .arm_kind_i(arm_kind),
    .arm_addr_i(arm_addr),
    .arm_data_i(arm_data),
    .apply_o   (apply),
    .kind_o    (pg_kind),
    .addr_o    (pg_addr),
    .data_o    (pg_data)
  );

  mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .apply_i  (apply),
    .kind_i   (pg_kind),
    .addr_i   (pg_addr),
    .data_i   (pg_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  assert_edge_single_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    sk_rise |=> !sk_rise);

endmodule

// File: tb/mw_regfile_slave_tb.sv
module mw_regfile_slave_tb_top;

  localparam int PROG = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sk = 1'b0;
  logic di = 1'b0;
  logic dout;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [15:0] exp_mem [16];
  bit exp_en = 1'b0;

  always #5 clk = ~clk;

  mw_regfile_slave #(.PROG_CYCLES(PROG)) dut_i (
    .clk_i (clk),
    .rst_ni(rst_n),
    .cs_i  (cs),
    .sk_i  (sk),
    .di_i  (di),
    .do_o  (dout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic obs);
    di = b;
    repeat (8) @(negedge clk);
    obs = dout;
    sk = 1'b1;
    repeat (8) @(negedge clk);
    sk = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    logic o;
    for (int k = n - 1; k >= 0; k--) clk_bit(v[k], o);
  endtask

  task automatic sel();
    cs = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic desel(input int n);
    cs = 1'b0;
    sk = 1'b0;
    di = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] op, input logic [5:0] tail);
    send_bits({7'd0, 1'b1, op, tail}, 9);
  endtask

  task automatic t_write(input int a, input logic [15:0] d);
    sel(); frame(2'b10, {2'b00, 4'(a)}); send_bits(d, 16); desel(PROG + 12);
    if (exp_en) exp_mem[a] = d;
  endtask

  task automatic t_erase(input int a);
    sel(); frame(2'b01, {2'b00, 4'(a)}); desel(PROG + 12);
    if (exp_en) exp_mem[a] = 16'hFFFF;
  endtask

  task automatic t_fill(input logic [15:0] d);
    sel(); frame(2'b11, 6'b000100); send_bits(d, 16); desel(PROG + 12);
    if (exp_en) for (int i = 0; i < 16; i++) exp_mem[i] = d;
  endtask

  task automatic t_wipe();
    sel(); frame(2'b11, 6'b000101); desel(PROG + 12);
    if (exp_en) for (int i = 0; i < 16; i++) exp_mem[i] = 16'hFFFF;
  endtask

  task automatic t_enable();
    sel(); frame(2'b11, 6'b000001); desel(12); exp_en = 1'b1;
  endtask

  task automatic t_disable();
    sel(); frame(2'b11, 6'b000010); desel(12); exp_en = 1'b0;
  endtask

  task automatic t_read(input int a, input int zeros, input string req);
    logic obs;
    logic [16:0] got = '0;
    sel();
    send_bits(16'd0, zeros);
    frame(2'b00, {2'b11, 4'(a)});
    for (int k = 0; k < 17; k++) begin
      clk_bit(k[0] ^ k[2], obs);
      got = {got[15:0], obs};
    end
    chk({req, " R4 dummy+data"}, {15'd0, got}, {15'd0, 1'b0, exp_mem[a]});
    di = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 echo high", {31'd0, dout}, 32'd1);
    di = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 echo low", {31'd0, dout}, 32'd0);
    desel(12);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) exp_mem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 output after reset", {31'd0, dout}, 32'd0);
    t_read(5, 0, "R1 reset contents");

    t_write(2, 16'hA5C3);
    t_read(2, 0, "R9 write while disabled");

    t_enable();
    t_write(2, 16'hA5C3);
    t_read(2, 3, "R2 R6 write after enable");
    t_write(15, 16'h8001);
    t_read(15, 1, "R6 second write");

    t_erase(2);
    t_read(2, 0, "R7 erase word");

    sel(); frame(2'b10, 6'b000100); send_bits(16'h3FF, 10); desel(PROG + 12);
    t_read(4, 0, "R10 short data");
    sel(); send_bits(16'b110, 3); desel(PROG + 12);
    t_read(2, 0, "R10 short frame");

    sel(); frame(2'b10, 6'b001111); send_bits(16'h1234, 16); desel(10);
    sel(); desel(PROG + 12);
    t_read(15, 0, "R11 early reselect");

    sel(); frame(2'b11, 6'b000001); frame(2'b01, 6'b001111); desel(PROG + 12);
    t_read(15, 0, "R12 second frame ignored");

    t_disable();
    sel(); frame(2'b11, 6'b100001); desel(12);
    t_write(7, 16'h7777);
    t_read(7, 0, "R3 bad extended pattern");
    sel(); frame(2'b11, 6'b000011); desel(12);
    t_write(7, 16'h7777);
    t_read(7, 0, "R3 unknown subcode");

    t_enable();
    t_fill(16'h3C5A);
    t_read(0, 0, "R8 fill word 0");
    t_read(9, 0, "R8 fill word 9");
    t_wipe();
    t_read(15, 0, "R8 wipe word 15");
    t_write(6, 16'h0F0F);
    t_read(6, 0, "R6 write after wipe");

    t_disable();
    t_erase(6);
    t_read(6, 0, "R9 erase after disable");
    t_wipe();
    t_read(6, 0, "R9 wipe after disable");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule